// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Timer

This block is one down-counting timer channel that emits an active-low pulse of a programmed length each time its gate input rises. A new rising edge on the gate while a pulse is running reloads the counter, so the pulse always ends a full programmed length after the most recent edge. The output stays high while the gate sits at a constant level, high or low.

The length comes from a count register, loaded through a valid/ready write port. The port never applies back-pressure: `wr_ready` stays high, and a beat is taken on every clock edge where `wr_valid` is high. A written length affects only pulses that start at later triggers. The live count is always visible on a plain read output, and reading it has no side effect. A stored value of zero stands for the full counter range, 2^CNT_W clocks. The gate, the write port and the counter all act on the rising clock edge.

Top module: `oneshot_timer`

## Requirements
- R1: While reset is active and right after it is released, `pulse_n` is 1, `rd_count` is 0 and `wr_ready` is 1. The count register resets to 0.
- R2: `wr_ready` is always 1. A beat with `wr_valid` high stores `wr_data` at that clock edge. The stored value sets the length of later pulses, and a stored 0 means a length of 65536 clocks (CNT_W=16).
- R3: A gate rising edge is a clock edge where `gate_in` is 1 and was 0 at the previous edge. After a rising edge, `pulse_n` is 0 from the next cycle, and `rd_count` shows the stored length (0 for 65536).
- R4: With no further rising edge, `pulse_n` stays 0 for exactly N cycles after the triggering edge, where N is the stored length. It then returns to 1.
- R5: While a pulse runs with no new trigger, `rd_count` drops by exactly 1 each cycle, and a write to the count register does not change it.
- R6: A rising edge during a pulse reloads the full stored length. The pulse then ends exactly N cycles after that latest edge.
- R7: With no pulse running and no rising edge, `pulse_n` stays 1 and `rd_count` stays 0. This includes a gate held high, and a gate already high when reset is released.
- R8: If a write and a trigger fall on the same clock edge, the trigger uses the length stored before that edge. The new value is used from the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_in | input | 1 | Gate; a rising edge starts or restarts a pulse |
| wr_valid | input | 1 | Count write beat valid |
| wr_ready | output | 1 | Count write ready, always 1 |
| wr_data | input | CNT_W (16) | Pulse length to store; 0 means 2^CNT_W |
| rd_count | output | CNT_W (16) | Live counter value; 0 when idle |
| pulse_n | output | 1 | Active-low one-shot output |

## Verification
The checker tests every cycle that a gate rising edge makes the output low in the next cycle, with the counter loaded from the previously stored length. It also checks that a running count drops by exactly one each cycle whatever is written, that the output goes high right after the count of one, and that the idle state holds with the output high. The bench scenarios cover properties that span a whole pulse: the measured low time equals the stored length, including the 65536-clock case for a stored zero; a retrigger stretches the pulse; and a value written during a pulse, or on the triggering edge, shows up only at the following trigger.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    OS_IDLE  = 1'b0,
    OS_PULSE = 1'b1
  } os_state_e;

  function automatic logic [16:0] span_of(input logic [15:0] raw);
    return (raw == 16'd0) ? 17'h10000 : {1'b0, raw};
  endfunction
endpackage

// File: rtl/oneshot_gate_edge.sv
module oneshot_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_prev,
  output logic gate_rise
);
  // Reset value 1: a gate already high at reset release is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) gate_prev <= 1'b1;
    else        gate_prev <= gate_in;
  end

  assign gate_rise = gate_in & ~gate_prev;
endmodule

// File: rtl/oneshot_len_reg.sv
module oneshot_len_reg #(
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] len_raw,
  output logic [LEN_W-1:0] len_full
);
  always_ff @(posedge clk) begin
    if (!rst_n)       len_raw <= '0;
    else if (wr_fire) len_raw <= wr_data;
  end

  // Zero encodes the full range of the counter.
  assign len_full = (len_raw == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, len_raw};
endmodule

// File: rtl/oneshot_downcount.sv
module oneshot_downcount
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  output logic [LEN_W-1:0] cnt,
  output os_state_e        state
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  os_state_e        state_d;
  logic [LEN_W-1:0] cnt_d;

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    if (load) begin
      state_d = OS_PULSE;
      cnt_d   = load_len;
    end else if (state == OS_PULSE) begin
      if (cnt == ONE) begin
        state_d = OS_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= OS_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_d;
      cnt   <= cnt_d;
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_in,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_count,
  output logic             pulse_n
);
  localparam int LEN_W = CNT_W + 1;

  logic             gate_prev;
  logic             gate_rise;
  logic [CNT_W-1:0] len_raw;
  logic [LEN_W-1:0] len_full;
  logic [LEN_W-1:0] cnt;
  os_state_e        state;

  assign wr_ready = 1'b1;

  oneshot_gate_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_in   (gate_in),
    .gate_prev (gate_prev),
    .gate_rise (gate_rise)
  );

  oneshot_len_reg #(.CNT_W(CNT_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_valid & wr_ready),
    .wr_data  (wr_data),
    .len_raw  (len_raw),
    .len_full (len_full)
  );

  oneshot_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gate_rise),
    .load_len (len_full),
    .cnt      (cnt),
    .state    (state)
  );

  assign rd_count = cnt[CNT_W-1:0];
  assign pulse_n  = (state == OS_IDLE);
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_in,
  input logic             gate_prev,
  input logic             wr_ready,
  input logic [CNT_W-1:0] len_raw,
  input logic [CNT_W-1:0] rd_count,
  input logic             pulse_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic trig;
  assign trig = gate_in & ~gate_prev;

  always @(posedge clk) if (rst_n) assert_ready_high_R2: assert (wr_ready);

  assert_trigger_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (!pulse_n && rd_count == $past(len_raw)));

  assert_terminal_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_n && rd_count == ONE && !trig) |=> (pulse_n && rd_count == '0));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_n && rd_count != ONE && !trig) |=> (!pulse_n && rd_count == $past(rd_count) - ONE));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_n && !trig) |=> (pulse_n && rd_count == '0));
endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_in   (gate_in),
  .gate_prev (gate_prev),
  .wr_ready  (wr_ready),
  .len_raw   (len_raw),
  .rd_count  (rd_count),
  .pulse_n   (pulse_n)
);

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate_in = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready;
  logic [15:0] rd_count;
  logic        pulse_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;  // 250 MHz

  oneshot_timer uut (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_count(rd_count), .pulse_n(pulse_n)
  );

  // Reference model built from the requirements
  logic [15:0] m_len;
  logic [16:0] m_cnt;
  logic        m_act;
  logic        m_gp;
  string       m_tag = "R1";

  function automatic logic [16:0] full_len(input logic [15:0] v);
    return (v == 16'd0) ? 17'h10000 : {1'b0, v};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_len <= '0; m_cnt <= '0; m_act <= 1'b0; m_gp <= 1'b1; m_tag <= "R1";
    end else begin
      if (gate_in && !m_gp) begin
        m_cnt <= full_len(m_len); m_act <= 1'b1;
        m_tag <= wr_valid ? "R8" : (m_act ? "R6" : "R3");
      end else if (m_act) begin
        if (m_cnt == 17'd1) begin m_cnt <= '0; m_act <= 1'b0; m_tag <= "R4"; end
        else begin m_cnt <= m_cnt - 17'd1; m_tag <= "R5"; end
      end else m_tag <= "R7";
      if (wr_valid) m_len <= wr_data;
      m_gp <= gate_in;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cyc);
    summary();
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(m_tag, {31'd0, pulse_n}, {31'd0, ~m_act}, "pulse_n");
    check(m_tag, {16'd0, rd_count}, {16'd0, m_cnt[15:0]}, "rd_count");
  endtask

  task automatic step(input logic g, input logic wv, input logic [15:0] wd);
    @(negedge clk);
    compare();
    gate_in = g; wr_valid = wv; wr_data = wd;
  endtask

  // Counts low cycles after the inputs that cause a trigger were driven
  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      step(gate_in, 1'b0, 16'd0);
      if (pulse_n) break;
      n++;
    end
  endtask

  int len;

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'd0, pulse_n}, 32'd1, "reset pulse_n");
    check("R1", {16'd0, rd_count}, 32'd0, "reset rd_count");
    check("R2", {31'd0, wr_ready}, 32'd1, "wr_ready");
    gate_in = 1'b1;  // held high across reset release: no trigger (R7)
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(1'b1, 1'b0, 16'd0);
    check("R7", {31'd0, pulse_n}, 32'd1, "gate high at reset release");

    // R4: basic length
    step(1'b0, 1'b1, 16'd5);
    step(1'b1, 1'b0, 16'd0);
    measure(len);
    check("R4", len, 32'd5, "pulse length 5");
    repeat (5) step(1'b1, 1'b0, 16'd0);
    check("R7", {31'd0, pulse_n}, 32'd1, "gate held high stays idle");

    // R6: retrigger
    step(1'b0, 1'b1, 16'd6);
    step(1'b1, 1'b0, 16'd0);
    step(1'b1, 1'b0, 16'd0);
    step(1'b0, 1'b0, 16'd0);
    step(1'b1, 1'b0, 16'd0);
    measure(len);
    check("R6", len, 32'd6, "length after retrigger");

    // R5/R2: write during pulse does not change it, next trigger uses it
    step(1'b0, 1'b1, 16'd4);
    step(1'b1, 1'b0, 16'd0);
    step(1'b1, 1'b1, 16'd9);
    measure(len);
    check("R5", len, 32'd3, "write in pulse keeps length (remaining)");
    step(1'b0, 1'b0, 16'd0);
    step(1'b1, 1'b0, 16'd0);
    measure(len);
    check("R2", len, 32'd9, "new length at next trigger");

    // R8: write on the trigger edge
    step(1'b0, 1'b0, 16'd0);
    step(1'b1, 1'b1, 16'd2);
    measure(len);
    check("R8", len, 32'd9, "same-edge write uses old length");
    step(1'b0, 1'b0, 16'd0);
    step(1'b1, 1'b0, 16'd0);
    measure(len);
    check("R8", len, 32'd2, "same-edge write used next time");

    // R2: zero means 65536
    step(1'b0, 1'b1, 16'd0);
    step(1'b1, 1'b0, 16'd0);
    measure(len);
    check("R2", len, 32'd65536, "zero length is 65536");

    // Random phase against model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic g, wv;
      logic [15:0] d;
      g  = ($urandom % 4) != 0 ? gate_in : ~gate_in;
      wv = ($urandom % 8) == 0;
      d  = 16'($urandom % 24);
      step(g, wv, d);
    end
    step(1'b0, 1'b0, 16'd0);
    summary();
  end
endmodule